// File: doc/BRIEF.md
# Parallel Rectifier Carrier PWM Modulator

This block drives the gates of two single-phase rectifier bridges that feed one shared DC link. Each bridge has two legs, so there are four legs in all. The controller gives three signed control voltages: one for bridge A, one for bridge B, and one for the circulating path between the bridges. It also gives the DC-link reference, a blending factor and a carrier-mode select. From these the block works out four pole-voltage references. It places them inside the available voltage window through a free common offset. It then compares each reference with a triangular carrier and drives a complementary upper/lower gate pair per leg, with a programmable dead time between the two gates.

The common offset is set between its lowest and highest legal value by the blending factor. Its value decides where the pulses of each bridge sit inside the carrier half period. In double-carrier mode the legs of bridge B use a second carrier that is shifted by half a carrier period. This interleaves the two bridges. All references are captured once per carrier period, at the carrier valley.

Top module: `dual_bridge_pwm`

## Requirements
- R1: The carrier counter counts 0, 1, …, CAR_MAX, CAR_MAX−1, …, 1, 0, 1, … (period 2·CAR_MAX cycles). All reference inputs and the mode select are captured on the clock edge that ends a cycle in which the counter is 0. They are used from the next cycle on and are held for the rest of the period.
- R2: Leg 0 (bridge A, first leg) gets pole = va + vx. Leg 1 (bridge A, second leg) gets pole = vx.
- R3: Leg 2 (bridge B, first leg) gets pole = floor((va + vb − vo)/2) + vx. Leg 3 (bridge B, second leg) gets pole = floor((va − vb − vo)/2) + vx.
- R4: Let h = floor(vdc/2). Take the four poles computed with vx = 0. vmax is the largest of them and vmin the smallest. Then hi_lim = h − vmax and lo_lim = −h − vmin. For mu = 255, vx = hi_lim. Otherwise vx = (mu·hi_lim + (256 − mu)·lo_lim)/256, rounded toward zero. In both cases vx is then clamped to [−h, h].
- R5: Each final pole is clamped to [−h, h].
- R6: A leg's demand is 1 when (pole + h)·(CAR_MAX + 1) > c·2h, where c is the carrier value seen by that leg. The demand is registered one cycle after the counter value it uses. With vdc = 0 no demand is ever set.
- R7: With dual_carrier = 0 all legs use c = counter. With dual_carrier = 1, legs 0 and 1 use c = counter and legs 2 and 3 use c = CAR_MAX − counter.
- R8: With mu = 0 the leg with the smallest pole sits at −h, so its upper gate stays off for a whole period. With mu = 255 the leg with the largest pole sits at +h, so its upper gate stays on for a whole period (when dead time is 0).
- R9: When a leg's registered demand changes, both of its gates go low for dead_cyc + 1 cycles. After that the gate that matches the demand goes high: gate_hi for demand 1, gate_lo for demand 0. gate_hi and gate_lo of one leg are never high together.
- R10: While rst is high all gates are low, the counter is 0 and counting up, and the captured references are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| va_ref | input | REF_W | Signed bridge A control voltage |
| vb_ref | input | REF_W | Signed bridge B control voltage |
| vo_ref | input | REF_W | Signed circulating-path control voltage |
| vdc_ref | input | REF_W | Unsigned DC-link reference |
| mu | input | 8 | Offset blend factor, Q0.8, 255 means 1 |
| dual_carrier | input | 1 | 1 selects the half-period-shifted carrier for bridge B |
| dead_cyc | input | DT_W | Dead time in clock cycles |
| gate_hi | output | 4 | Upper gate per leg (bit = leg index) |
| gate_lo | output | 4 | Lower gate per leg (bit = leg index) |

## Verification
A behavioural reference model predicts all eight gates on every clock. It is run under several sets of control voltages. One set uses only the bridge A voltage, which isolates the bridge A legs. Others add bridge B and circulating voltages, which exercise the halved B-leg sums. Further sets sweep mu over 0, a middle value and 255, and use oversized inputs that force both clamps. Inputs are changed in the middle of a period, so a design that captures outside the valley is exposed. Dual-carrier mode is compared with single-carrier mode on the same references, which shows whether the carrier routing is correct. Extra sets cover a zero and an odd DC-link value and several dead times. Full-period gate counts at mu = 0 and mu = 255 show that the offset pushes one leg onto each rail.

// File: rtl/brg_pwm_pkg.sv
package brg_pwm_pkg;

    typedef enum logic {
        CAR_SINGLE = 1'b0,
        CAR_DUAL   = 1'b1
    } car_mode_e;

    localparam int NUM_LEGS = 4;

    typedef enum logic [1:0] {
        LEG_A1 = 2'd0,
        LEG_A2 = 2'd1,
        LEG_B1 = 2'd2,
        LEG_B2 = 2'd3
    } leg_e;

    // Bridge B legs move to the shifted carrier in dual mode
    function automatic logic uses_shifted(car_mode_e m, int leg);
        return (m == CAR_DUAL) && (leg >= int'(LEG_B1));
    endfunction

endpackage

// File: rtl/brg_carrier.sv
module brg_carrier #(
    parameter int CAR_MAX = 64,
    localparam int CW = $clog2(CAR_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt,
    output logic          valley
);
    logic up;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            up  <= 1'b1;
        end else if (up) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(CAR_MAX - 1)) up <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) up <= 1'b1;
        end
    end

    assign valley = (cnt == '0);
endmodule

// File: rtl/brg_pole_calc.sv
module brg_pole_calc #(
    parameter int REF_W = 12,
    localparam int PW = REF_W + 3
) (
    input  logic signed [REF_W-1:0] va,
    input  logic signed [REF_W-1:0] vb,
    input  logic signed [REF_W-1:0] vo,
    input  logic signed [PW-1:0]    half,
    input  logic        [7:0]       mu,
    output logic signed [PW-1:0]    pole [4]
);
    localparam int MW = PW + 10;
    typedef logic signed [PW-1:0] pw_t;
    typedef logic signed [MW-1:0] mw_t;

    pw_t va_x, vb_x, vo_x, sum_p, sum_n;
    pw_t p0 [4];
    pw_t vmax, vmin, hi_lim, lo_lim, vx;
    mw_t mu_w, nmu_w, acc, quot, vx_w, half_w;

    assign va_x  = PW'(va);
    assign vb_x  = PW'(vb);
    assign vo_x  = PW'(vo);
    assign sum_p = va_x + vb_x - vo_x;
    assign sum_n = va_x - vb_x - vo_x;

    // Poles with zero offset
    assign p0[0] = va_x;
    assign p0[1] = '0;
    assign p0[2] = sum_p >>> 1;
    assign p0[3] = sum_n >>> 1;

    always_comb begin
        vmax = p0[0];
        vmin = p0[0];
        for (int i = 1; i < 4; i++) begin
            if (p0[i] > vmax) vmax = p0[i];
            if (p0[i] < vmin) vmin = p0[i];
        end
    end

    assign hi_lim = half - vmax;
    assign lo_lim = -half - vmin;

    // Blend the two limits, divide by 256 toward zero
    assign mu_w   = MW'(mu);
    assign nmu_w  = mw_t'(256) - mu_w;
    assign acc    = mu_w * MW'(hi_lim) + nmu_w * MW'(lo_lim);
    assign quot   = acc[MW-1] ? -((-acc) >>> 8) : (acc >>> 8);
    assign half_w = MW'(half);

    always_comb begin
        vx_w = (mu == 8'hFF) ? MW'(hi_lim) : quot;
        if (vx_w > half_w)       vx_w = half_w;
        else if (vx_w < -half_w) vx_w = -half_w;
    end

    assign vx = PW'(vx_w);

    for (genvar g = 0; g < 4; g++) begin : g_pole
        pw_t raw;
        assign raw = p0[g] + vx;
        always_comb begin
            if (raw > half)       pole[g] = half;
            else if (raw < -half) pole[g] = -half;
            else                  pole[g] = raw;
        end
    end
endmodule

// File: rtl/brg_deadtime.sv
module brg_deadtime #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            demand,
    input  logic [DT_W-1:0] dead,
    output logic            hi,
    output logic            lo
);
    logic            prev;
    logic [DT_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            tmr  <= '0;
            hi   <= 1'b0;
            lo   <= 1'b0;
        end else if (demand != prev) begin
            prev <= demand;
            tmr  <= dead;
            hi   <= 1'b0;
            lo   <= 1'b0;
        end else if (tmr != '0) begin
            tmr  <= tmr - 1'b1;
            hi   <= 1'b0;
            lo   <= 1'b0;
        end else begin
            hi   <= prev;
            lo   <= ~prev;
        end
    end
endmodule

// File: rtl/dual_bridge_pwm.sv
module dual_bridge_pwm
    import brg_pwm_pkg::*;
#(
    parameter int REF_W   = 12,
    parameter int CAR_MAX = 64,
    parameter int DT_W    = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [REF_W-1:0] va_ref,
    input  logic signed [REF_W-1:0] vb_ref,
    input  logic signed [REF_W-1:0] vo_ref,
    input  logic        [REF_W-1:0] vdc_ref,
    input  logic        [7:0]       mu,
    input  logic                    dual_carrier,
    input  logic        [DT_W-1:0]  dead_cyc,
    output logic        [3:0]       gate_hi,
    output logic        [3:0]       gate_lo
);
    localparam int CNT_W = $clog2(CAR_MAX + 1);
    localparam int PW    = REF_W + 3;
    localparam int CMPW  = PW + CNT_W + 2;

    typedef struct packed {
        logic signed [REF_W-1:0] va;
        logic signed [REF_W-1:0] vb;
        logic signed [REF_W-1:0] vo;
        logic        [REF_W-1:0] vdc;
        logic        [7:0]       mu;
        car_mode_e               mode;
    } ref_set_t;

    ref_set_t                lat_q;
    logic [CNT_W-1:0]        car_cnt, car_shift;
    logic                    valley;
    logic signed [PW-1:0]    half;
    logic signed [PW-1:0]    pole [4];
    logic [NUM_LEGS-1:0]     dem_q;

    brg_carrier #(.CAR_MAX(CAR_MAX)) u_car (
        .clk(clk), .rst(rst), .cnt(car_cnt), .valley(valley)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else if (valley) begin
            lat_q <= '{va: va_ref, vb: vb_ref, vo: vo_ref, vdc: vdc_ref,
                       mu: mu, mode: car_mode_e'(dual_carrier)};
        end
    end

    assign half      = PW'({1'b0, lat_q.vdc[REF_W-1:1]});
    assign car_shift = CNT_W'(CAR_MAX) - car_cnt;

    brg_pole_calc #(.REF_W(REF_W)) u_pole (
        .va(lat_q.va), .vb(lat_q.vb), .vo(lat_q.vo),
        .half(half), .mu(lat_q.mu), .pole(pole)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        logic [CNT_W-1:0]       c_sel;
        logic signed [CMPW-1:0] lvl, lhs, rhs;

        assign c_sel = uses_shifted(lat_q.mode, g) ? car_shift : car_cnt;
        assign lvl   = CMPW'(pole[g]) + CMPW'(half);
        assign lhs   = lvl * CMPW'(CAR_MAX + 1);
        assign rhs   = $signed(CMPW'(c_sel)) * (CMPW'(half) <<< 1);

        always_ff @(posedge clk) begin
            if (rst) dem_q[g] <= 1'b0;
            else     dem_q[g] <= (lhs > rhs);
        end

        brg_deadtime #(.DT_W(DT_W)) u_dt (
            .clk(clk), .rst(rst), .demand(dem_q[g]), .dead(dead_cyc),
            .hi(gate_hi[g]), .lo(gate_lo[g])
        );
    end
endmodule

// File: rtl/brg_pwm_chk.sv
module brg_pwm_chk #(
    parameter int REF_W   = 12,
    parameter int CAR_MAX = 64,
    localparam int CNT_W  = $clog2(CAR_MAX + 1),
    localparam int PW     = REF_W + 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [CNT_W-1:0]     car_cnt,
    input logic [4*REF_W+8:0]   lat_refs,
    input logic [REF_W-1:0]     lat_vdc,
    input logic signed [PW-1:0] pole [4],
    input logic [3:0]           gate_hi,
    input logic [3:0]           gate_lo
);
    logic signed [PW-1:0] hc;
    assign hc = {4'b0, lat_vdc[REF_W-1:1]};

    // R1
    carrier_range_chk: assert property (@(posedge clk) disable iff (rst)
        car_cnt <= CNT_W'(CAR_MAX));

    // R1
    latch_valley_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(lat_refs) |-> $past(car_cnt) == '0);

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == 4'b0);

    // R9
    hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & ~$past(gate_hi) & $past(gate_lo)) == 4'b0);

    // R9
    lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_lo & ~$past(gate_lo) & $past(gate_hi)) == 4'b0);

    for (genvar g = 0; g < 4; g++) begin : g_rng
        // R5
        pole_range_chk: assert property (@(posedge clk) disable iff (rst)
            (pole[g] <= hc) && (pole[g] >= -hc));
    end
endmodule

bind dual_bridge_pwm brg_pwm_chk #(.REF_W(REF_W), .CAR_MAX(CAR_MAX)) u_chk (
    .clk(clk), .rst(rst), .car_cnt(car_cnt), .lat_refs(lat_q),
    .lat_vdc(lat_q.vdc), .pole(pole), .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/test_dual_bridge_pwm.sv
module test_dual_bridge_pwm;
    localparam int REF_W = 12;
    localparam int M     = 20;
    localparam int DT_W  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [REF_W-1:0] va_ref = '0, vb_ref = '0, vo_ref = '0;
    logic [REF_W-1:0] vdc_ref = '0;
    logic [7:0] mu = '0;
    logic dual_carrier = 1'b0;
    logic [DT_W-1:0] dead_cyc = '0;
    logic [3:0] gate_hi, gate_lo;

    always #5 clk = ~clk;

    dual_bridge_pwm #(.REF_W(REF_W), .CAR_MAX(M), .DT_W(DT_W)) i_dual_bridge_pwm (
        .clk(clk), .rst(rst), .va_ref(va_ref), .vb_ref(vb_ref), .vo_ref(vo_ref),
        .vdc_ref(vdc_ref), .mu(mu), .dual_carrier(dual_carrier),
        .dead_cyc(dead_cyc), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    int checks = 0, errors = 0;
    bit run_cmp = 0, done = 0;
    string tag = "R10";

    // Reference model state
    int m_cnt, m_up, l_va, l_vb, l_vo, l_vdc, l_mu, l_mode;
    bit [3:0] dem, prv, ehi, elo;
    int tmr [4];

    function automatic int clampi(int x, int h);
        if (x > h) return h;
        if (x < -h) return -h;
        return x;
    endfunction

    function automatic bit model_demand(int leg);
        int h, p [4], q [4], mx, mn, hl, ll, vx, c;
        h = l_vdc / 2;
        p[0] = l_va; p[1] = 0;
        p[2] = (l_va + l_vb - l_vo) >>> 1;
        p[3] = (l_va - l_vb - l_vo) >>> 1;
        mx = p[0]; mn = p[0];
        foreach (p[i]) begin
            if (p[i] > mx) mx = p[i];
            if (p[i] < mn) mn = p[i];
        end
        hl = h - mx;
        ll = -h - mn;
        if (l_mu == 255) vx = hl;
        else vx = (l_mu * hl + (256 - l_mu) * ll) / 256;
        vx = clampi(vx, h);
        foreach (q[i]) q[i] = clampi(p[i] + vx, h);
        c = (l_mode == 1 && leg >= 2) ? (M - m_cnt) : m_cnt;
        return (q[leg] + h) * (M + 1) > c * 2 * h;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_up = 1;
            l_va = 0; l_vb = 0; l_vo = 0; l_vdc = 0; l_mu = 0; l_mode = 0;
            dem = '0; prv = '0; ehi = '0; elo = '0;
            foreach (tmr[i]) tmr[i] = 0;
        end else begin
            bit [3:0] nd;
            for (int l = 0; l < 4; l++) begin
                if (dem[l] != prv[l]) begin
                    prv[l] = dem[l]; tmr[l] = int'(dead_cyc); ehi[l] = 0; elo[l] = 0;
                end else if (tmr[l] != 0) begin
                    tmr[l] = tmr[l] - 1; ehi[l] = 0; elo[l] = 0;
                end else begin
                    ehi[l] = prv[l]; elo[l] = !prv[l];
                end
            end
            for (int l = 0; l < 4; l++) nd[l] = model_demand(l);
            if (m_cnt == 0) begin
                l_va = int'(va_ref); l_vb = int'(vb_ref); l_vo = int'(vo_ref);
                l_vdc = int'(vdc_ref); l_mu = int'(mu); l_mode = int'(dual_carrier);
            end
            if (m_up == 1) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == M) m_up = 0;
            end else begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) m_up = 1;
            end
            dem = nd;
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            checks++;
            if (gate_hi !== 4'b0 || gate_lo !== 4'b0) begin
                errors++;
                $display("FAIL R10 reset: hi=%b lo=%b expected 0000/0000", gate_hi, gate_lo);
            end
        end else if (run_cmp) begin
            checks++;
            if (gate_hi !== ehi || gate_lo !== elo) begin
                errors++;
                $display("FAIL %s at %0t: hi=%b lo=%b expected hi=%b lo=%b",
                         tag, $time, gate_hi, gate_lo, ehi, elo);
            end
        end
    end

    task automatic setv(int a, int b, int o, int dc, int m);
        va_ref = REF_W'(a); vb_ref = REF_W'(b); vo_ref = REF_W'(o);
        vdc_ref = REF_W'(dc); mu = 8'(m);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // R8: count upper-gate on cycles of one leg over a full period
    task automatic rail_check(int leg, int expect_on);
        int on_cnt = 0;
        for (int i = 0; i < 2 * M; i++) begin
            @(negedge clk);
            if (gate_hi[leg]) on_cnt++;
        end
        checks++;
        if (on_cnt != expect_on) begin
            errors++;
            $display("FAIL R8 leg %0d upper on %0d cycles, expected %0d", leg, on_cnt, expect_on);
        end
    endtask

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        run_cmp = 1;
        dead_cyc = 4'd2;
        tag = "R2"; setv(300, 0, 0, 1600, 128); wait_cyc(6 * M);
        tag = "R3"; setv(-200, 500, -300, 1600, 100); wait_cyc(6 * M);
        tag = "R4"; setv(400, -350, 120, 1800, 0); wait_cyc(4 * M);
        mu = 8'd255; wait_cyc(4 * M);
        mu = 8'd77; wait_cyc(4 * M);
        tag = "R5"; setv(2000, -2000, 1500, 1000, 200); wait_cyc(6 * M);
        tag = "R7"; setv(-200, 500, -300, 1600, 100); dual_carrier = 1'b1; wait_cyc(6 * M);
        dual_carrier = 1'b0; wait_cyc(4 * M);
        tag = "R9"; dead_cyc = 4'd0; setv(250, 100, 50, 1400, 128); wait_cyc(4 * M);
        dead_cyc = 4'd7; wait_cyc(4 * M);
        tag = "R1"; dead_cyc = 4'd1;
        for (int k = 0; k < 12; k++) begin
            setv(-600 + 97 * k, 40 * k - 200, 15 * k, 1200 + 50 * k, 20 * k);
            wait_cyc(13);
        end
        wait_cyc(2 * M);
        tag = "R6"; setv(300, 100, 0, 0, 128); wait_cyc(4 * M);
        setv(300, 100, 0, 4095, 128); wait_cyc(4 * M);
        tag = "R8"; dead_cyc = 4'd0; setv(600, 0, 0, 2000, 0); wait_cyc(3 * M);
        rail_check(1, 0);
        mu = 8'd255; wait_cyc(3 * M);
        rail_check(0, 2 * M);
        run_cmp = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule